// File: doc/BRIEF.md
# Prioritized Four-Source Word Packer

This block merges four narrow word sources into one stream of wide words for a bulk host link. Each source sits behind a small FIFO. The block sees whether that FIFO holds data, pulls one word at a time with a request strobe, and takes the word when the source's valid strobe comes back one cycle later. When several sources hold data in the same cycle, a fixed priority decides which one is served: link packets first, then configuration data, then loopback traffic, then commands.

Accepted words are placed, in arrival order, into seven 32-bit slots of a 256-bit output word. The lowest 32 bits of that word form a tag. The tag records how many slots are in use, and for each slot the source port number and a 2-bit context, so the host can split the stream again. A full word is sent as soon as its seventh slot is filled. A partly filled word is sent after a fixed quiet period, so that slow traffic is not held back indefinitely. The configuration source carries no context of its own, and its context is always recorded as zero.

Top module: `prio_word_packer`

## Requirements
- R1: In each cycle the block asserts at most one request bit. The request goes to the lowest-numbered port whose has-data input is high, where port 0 has the highest priority. No request is raised when no port has data.
- R2: A word is stored only when the valid input of the port requested in the previous cycle is high. A valid strobe on any other port, or one that follows no request, is ignored and never appears in the output.
- R3: The output word has a fixed layout. Bits [2:0] hold the number of filled slots and bit 3 is zero. The field of slot i sits at bits [4+4i+3:4+4i]: its low two bits give the source port and its high two bits give the context. The data of slot i sits at bits [32(i+1)+31:32(i+1)]. Slots fill in arrival order, starting at slot 0.
- R4: For every slot at or above the filled count, both the tag field and the data are zero.
- R5: A word taken from port 1 is always tagged with context 0, whatever its context input carries.
- R6: When a seventh word is stored, the output valid is high in the cycle that follows the arrival cycle. It stays high for exactly one cycle, and the slots then start empty.
- R7: If at least one slot is filled and no word is stored for 64 consecutive cycles after the last arrival, the partial word is emitted. Its valid rises 65 cycles after the arrival cycle of its last word.
- R8: No request is raised in a cycle in which the output valid is high.
- R9: A synchronous active-high reset clears the slots, the quiet-period counter and the output valid, and no request is raised while reset is high. Words held at the time of reset are never emitted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| src_has_data_i | input | 4 | Per port: the source FIFO is not empty |
| src_req_o | output | 4 | Per port: pop one word (at most one bit set) |
| src_valid_i | input | 4 | Per port: the returned word is valid (one cycle after the request) |
| src_data_i | input | 4x32 | Per port data word, port p at bits [32p+31:32p] |
| src_ctx_i | input | 4x2 | Per port context, port p at bits [2p+1:2p] |
| link_word_o | output | 256 | Packed output word: tag in [31:0], slots above it |
| link_valid_o | output | 1 | Output word valid, a one-cycle pulse |

## Verification
Some properties are checked on every cycle by assertions: the request vector is one-hot or empty, it goes only to the highest-priority port that has data, and it is held low while a word is being emitted. The assertions also cover the emission that follows a seventh stored word or an expired quiet period, the one-cycle valid pulse, and the clearing done by reset. Other behaviour can only be shown by the bench scenarios. These cover the arrival order and placement of data in the slots, the zeroing of unused slots, the forced zero context on port 1, the rejection of a stray valid strobe, the exact 65-cycle flush latency, and the dropping of a partial word when reset arrives.

// File: rtl/agg_pkg.sv
package agg_pkg;

    localparam int DEF_DATA_W       = 32;
    localparam int DEF_CTX_W        = 2;
    localparam int DEF_PORTS        = 4;
    localparam int DEF_SLOTS        = 7;
    localparam int DEF_FLUSH_CYCLES = 64;
    localparam int DEF_CTXLESS_PORT = 1;

    typedef enum logic [1:0] {
        EMIT_NONE  = 2'd0,
        EMIT_FULL  = 2'd1,
        EMIT_FLUSH = 2'd2
    } emit_kind_e;

endpackage

// File: rtl/agg_arbiter.sv
module agg_arbiter #(
    parameter int NUM_PORTS = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_PORTS-1:0] has_data_i,
    input  logic                 hold_i,
    output logic [NUM_PORTS-1:0] req_o
);

    logic [NUM_PORTS-1:0] pick_w;

    // Fixed priority: the lowest index that has data wins.
    always_comb begin
        pick_w = '0;
        for (int i = NUM_PORTS - 1; i >= 0; i--) begin
            if (has_data_i[i]) begin
                pick_w    = '0;
                pick_w[i] = 1'b1;
            end
        end
        req_o = hold_i ? '0 : pick_w;
    end

    // R1
    one_grant_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(req_o));

    // R1
    grant_has_data_chk: assert property (@(posedge clk) disable iff (rst)
        (req_o & ~has_data_i) == '0);

    // R1
    grant_priority_chk: assert property (@(posedge clk) disable iff (rst)
        (req_o != '0) |-> ((has_data_i & (req_o - 1'b1)) == '0));

    // R1
    grant_when_free_chk: assert property (@(posedge clk) disable iff (rst)
        (!hold_i && has_data_i != '0) |-> (req_o != '0));

endmodule

// File: rtl/agg_word_builder.sv
module agg_word_builder #(
    parameter int DATA_W = 32,
    parameter int PORT_W = 2,
    parameter int CTX_W  = 2,
    parameter int SLOTS  = 7,
    parameter int CNT_W  = 3
) (
    input  logic [SLOTS-1:0][DATA_W-1:0]       slot_data_i,
    input  logic [SLOTS-1:0][PORT_W+CTX_W-1:0] slot_fld_i,
    input  logic [CNT_W-1:0]                   fill_i,
    output logic [DATA_W*(SLOTS+1)-1:0]        word_o
);

    localparam int FIELD_W  = PORT_W + CTX_W;
    localparam int TAG_BASE = DATA_W - SLOTS * FIELD_W;

    assign word_o[CNT_W-1:0] = fill_i;

    generate
        if (TAG_BASE > CNT_W) begin : g_pad
            assign word_o[TAG_BASE-1:CNT_W] = '0;
        end
        for (genvar i = 0; i < SLOTS; i++) begin : g_slot
            localparam logic [CNT_W-1:0] IDX = CNT_W'(i);
            logic used_w;
            assign used_w = (fill_i > IDX);
            assign word_o[TAG_BASE + i*FIELD_W +: FIELD_W] =
                used_w ? slot_fld_i[i] : '0;
            assign word_o[(i+1)*DATA_W +: DATA_W] =
                used_w ? slot_data_i[i] : '0;
        end
    endgenerate

endmodule

// File: rtl/agg_packer.sv
module agg_packer
    import agg_pkg::*;
#(
    parameter int DATA_W       = 32,
    parameter int CTX_W        = 2,
    parameter int NUM_PORTS    = 4,
    parameter int SLOTS        = 7,
    parameter int FLUSH_CYCLES = 64,
    parameter int CTXLESS_PORT = 1
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic [NUM_PORTS-1:0]                req_i,
    input  logic [NUM_PORTS-1:0]                src_valid_i,
    input  logic [NUM_PORTS-1:0][DATA_W-1:0]    src_data_i,
    input  logic [NUM_PORTS-1:0][CTX_W-1:0]     src_ctx_i,
    output logic [DATA_W*(SLOTS+1)-1:0]         word_o,
    output logic                                word_valid_o
);

    localparam int PORT_W  = $clog2(NUM_PORTS);
    localparam int CNT_W   = $clog2(SLOTS + 1);
    localparam int FIELD_W = PORT_W + CTX_W;
    localparam int OUT_W   = DATA_W * (SLOTS + 1);
    localparam int IDLE_W  = $clog2(FLUSH_CYCLES + 1);

    localparam logic [CNT_W-1:0]  FULL_CNT    = CNT_W'(SLOTS);
    localparam logic [CNT_W-1:0]  LAST_CNT    = CNT_W'(SLOTS - 1);
    localparam logic [IDLE_W-1:0] IDLE_LAST   = IDLE_W'(FLUSH_CYCLES - 1);
    localparam logic [PORT_W-1:0] CTXLESS_IDX = PORT_W'(CTXLESS_PORT);

    typedef struct packed {
        logic [SLOTS-1:0][DATA_W-1:0]  slot_data;
        logic [SLOTS-1:0][FIELD_W-1:0] slot_fld;
        logic [CNT_W-1:0]              fill;
        logic [IDLE_W-1:0]             idle;
        logic                          pend;
        logic [PORT_W-1:0]             pend_port;
        logic                          emit;
        logic [OUT_W-1:0]              word;
    } pk_state_t;

    pk_state_t s_d, s_q;

    logic                          store_w;
    logic [PORT_W-1:0]             src_port_w;
    logic [CTX_W-1:0]              src_ctx_w;
    logic [SLOTS-1:0][DATA_W-1:0]  stage_data_w;
    logic [SLOTS-1:0][FIELD_W-1:0] stage_fld_w;
    logic [CNT_W-1:0]              stage_fill_w;
    logic [OUT_W-1:0]              built_word_w;
    emit_kind_e                    emit_kind_w;

    // Accept the word returned for last cycle's request and stage it into the slots.
    always_comb begin
        src_port_w   = s_q.pend_port;
        store_w      = s_q.pend && src_valid_i[src_port_w];
        src_ctx_w    = (src_port_w == CTXLESS_IDX) ? '0 : src_ctx_i[src_port_w];
        stage_data_w = s_q.slot_data;
        stage_fld_w  = s_q.slot_fld;
        stage_fill_w = s_q.fill;
        if (store_w) begin
            stage_data_w[s_q.fill] = src_data_i[src_port_w];
            stage_fld_w[s_q.fill]  = {src_ctx_w, src_port_w};
            stage_fill_w           = s_q.fill + 1'b1;
        end
        if (store_w && stage_fill_w == FULL_CNT) begin
            emit_kind_w = EMIT_FULL;
        end else if (!store_w && s_q.fill != '0 && s_q.idle == IDLE_LAST) begin
            emit_kind_w = EMIT_FLUSH;
        end else begin
            emit_kind_w = EMIT_NONE;
        end
    end

    agg_word_builder #(
        .DATA_W (DATA_W),
        .PORT_W (PORT_W),
        .CTX_W  (CTX_W),
        .SLOTS  (SLOTS),
        .CNT_W  (CNT_W)
    ) u_builder (
        .slot_data_i (stage_data_w),
        .slot_fld_i  (stage_fld_w),
        .fill_i      (stage_fill_w),
        .word_o      (built_word_w)
    );

    always_comb begin
        s_d           = s_q;
        s_d.emit      = 1'b0;
        s_d.pend      = |req_i;
        s_d.pend_port = '0;
        for (int i = 0; i < NUM_PORTS; i++) begin
            if (req_i[i]) begin
                s_d.pend_port = PORT_W'(i);
            end
        end
        s_d.slot_data = stage_data_w;
        s_d.slot_fld  = stage_fld_w;
        s_d.fill      = stage_fill_w;
        if (store_w || stage_fill_w == '0) begin
            s_d.idle = '0;
        end else begin
            s_d.idle = s_q.idle + 1'b1;
        end
        if (emit_kind_w != EMIT_NONE) begin
            s_d.emit      = 1'b1;
            s_d.word      = built_word_w;
            s_d.slot_data = '0;
            s_d.slot_fld  = '0;
            s_d.fill      = '0;
            s_d.idle      = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign word_o       = s_q.word;
    assign word_valid_o = s_q.emit;

    // R6
    full_emit_chk: assert property (@(posedge clk) disable iff (rst)
        (store_w && s_q.fill == LAST_CNT) |=>
            (word_valid_o && word_o[CNT_W-1:0] == FULL_CNT));

    // R6
    single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        word_valid_o |=> !word_valid_o);

    // R7
    flush_emit_chk: assert property (@(posedge clk) disable iff (rst)
        (!store_w && s_q.fill != '0 && s_q.idle == IDLE_LAST) |=>
            (word_valid_o && word_o[CNT_W-1:0] == $past(s_q.fill)));

    // R9
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!word_valid_o && s_q.fill == '0 && s_q.idle == '0));

endmodule

// File: rtl/prio_word_packer.sv
module prio_word_packer
    import agg_pkg::*;
#(
    parameter int DATA_W       = DEF_DATA_W,
    parameter int CTX_W        = DEF_CTX_W,
    parameter int NUM_PORTS    = DEF_PORTS,
    parameter int SLOTS        = DEF_SLOTS,
    parameter int FLUSH_CYCLES = DEF_FLUSH_CYCLES,
    parameter int CTXLESS_PORT = DEF_CTXLESS_PORT
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic [NUM_PORTS-1:0]             src_has_data_i,
    output logic [NUM_PORTS-1:0]             src_req_o,
    input  logic [NUM_PORTS-1:0]             src_valid_i,
    input  logic [NUM_PORTS-1:0][DATA_W-1:0] src_data_i,
    input  logic [NUM_PORTS-1:0][CTX_W-1:0]  src_ctx_i,
    output logic [DATA_W*(SLOTS+1)-1:0]      link_word_o,
    output logic                             link_valid_o
);

    logic hold_w;

    // Requests pause during reset and in the emission cycle.
    assign hold_w = rst | link_valid_o;

    agg_arbiter #(
        .NUM_PORTS (NUM_PORTS)
    ) u_arb (
        .clk        (clk),
        .rst        (rst),
        .has_data_i (src_has_data_i),
        .hold_i     (hold_w),
        .req_o      (src_req_o)
    );

    agg_packer #(
        .DATA_W       (DATA_W),
        .CTX_W        (CTX_W),
        .NUM_PORTS    (NUM_PORTS),
        .SLOTS        (SLOTS),
        .FLUSH_CYCLES (FLUSH_CYCLES),
        .CTXLESS_PORT (CTXLESS_PORT)
    ) u_pack (
        .clk          (clk),
        .rst          (rst),
        .req_i        (src_req_o),
        .src_valid_i  (src_valid_i),
        .src_data_i   (src_data_i),
        .src_ctx_i    (src_ctx_i),
        .word_o       (link_word_o),
        .word_valid_o (link_valid_o)
    );

    // R8
    no_req_on_emit_chk: assert property (@(posedge clk) disable iff (rst)
        link_valid_o |-> (src_req_o == '0));

    // R9
    no_req_in_reset_chk: assert property (@(posedge clk)
        rst |-> (src_req_o == '0));

endmodule

// File: tb/tb_prio_word_packer.sv
module tb_prio_word_packer;

    logic             clk = 1'b0;
    logic             rst;
    logic [3:0]       has;
    logic [3:0]       req;
    logic [3:0]       vld;
    logic [3:0][31:0] dat;
    logic [3:0][1:0]  ctx;
    logic [255:0]     word;
    logic             wv;

    int     checks = 0;
    int     fails  = 0;
    longint cyc    = 0;
    int     full_cnt = 0;
    int     part_cnt = 0;

    logic [33:0] srcq [4][$];   // {ctx, data}
    logic [35:0] expq [$];      // {port, ctx, data}
    longint      expcyc [$];
    logic [3:0]  pend = '0;
    logic [33:0] pend_w [4];
    logic        spur_req = 1'b0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    prio_word_packer dut (
        .clk            (clk),
        .rst            (rst),
        .src_has_data_i (has),
        .src_req_o      (req),
        .src_valid_i    (vld),
        .src_data_i     (dat),
        .src_ctx_i      (ctx),
        .link_word_o    (word),
        .link_valid_o   (wv)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic push(input int p, input logic [31:0] d, input logic [1:0] c);
        srcq[p].push_back({c, d});
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    // Source model: returns the popped word one cycle after its request.
    initial begin
        vld = '0; dat = '0; ctx = '0; has = '0;
        forever begin
            @(negedge clk);
            vld = '0;
            if (rst) pend = '0;
            for (int p = 0; p < 4; p++) begin
                if (pend[p]) begin
                    vld[p] = 1'b1;
                    dat[p] = pend_w[p][31:0];
                    ctx[p] = pend_w[p][33:32];
                    // R5: port 1 is expected with context 0
                    expq.push_back({p[1:0], (p == 1) ? 2'b00 : pend_w[p][33:32], pend_w[p][31:0]});
                    expcyc.push_back(cyc);
                    pend[p] = 1'b0;
                end
            end
            if (spur_req && vld == '0) begin
                vld[3] = 1'b1;
                dat[3] = 32'hDEAD0003;
                ctx[3] = 2'b10;
                spur_req = 1'b0;
            end
            for (int p = 0; p < 4; p++) has[p] = (srcq[p].size() != 0);
            #1;
            if (!rst) begin
                logic [3:0] exp_req;
                exp_req = '0;
                if (!wv) begin
                    for (int p = 3; p >= 0; p--) if (has[p]) exp_req = 4'(1 << p);
                end
                chk(req == exp_req, wv ? "R8 request during emission" : "R1 priority request", 64'(req), 64'(exp_req));
                for (int p = 0; p < 4; p++) begin
                    if (req[p] && srcq[p].size() != 0) begin
                        pend_w[p] = srcq[p].pop_front();
                        pend[p]   = 1'b1;
                    end
                end
            end
        end
    end

    // Monitor: compares each emitted word against the scoreboard.
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (!rst && wv) begin
                int     n;
                longint lastc;
                n = int'(word[2:0]);
                lastc = 0;
                chk(n >= 1 && n <= 7, "R3 fill count range", 64'(n), 64'd7);
                chk(word[3] == 1'b0, "R3 pad bit", 64'(word[3]), 64'd0);
                for (int i = 0; i < 7; i++) begin
                    logic [3:0]  fld;
                    logic [31:0] sd;
                    fld = word[4 + 4*i +: 4];
                    sd  = word[32*(i+1) +: 32];
                    if (i < n) begin
                        if (expq.size() == 0) begin
                            chk(1'b0, "R2 unexpected stored word", 64'(sd), 64'd0);
                        end else begin
                            logic [35:0] e;
                            e = expq.pop_front();
                            lastc = expcyc.pop_front();
                            chk(sd == e[31:0], "R2 R3 slot data", 64'(sd), 64'(e[31:0]));
                            chk(fld == {e[33:32], e[35:34]},
                                (e[35:34] == 2'd1) ? "R5 slot field" : "R3 slot field",
                                64'(fld), 64'({e[33:32], e[35:34]}));
                        end
                    end else begin
                        chk(fld == 4'd0 && sd == 32'd0, "R4 unused slot zero", {28'd0, fld, sd}, 64'd0);
                    end
                end
                if (n == 7) begin
                    full_cnt++;
                    chk(cyc - lastc == 1, "R6 full emit latency", 64'(cyc - lastc), 64'd1);
                end else begin
                    part_cnt++;
                    chk(cyc - lastc == 65, "R7 flush latency", 64'(cyc - lastc), 64'd65);
                end
            end
        end
    end

    task automatic wait_drain();
        for (int k = 0; k < 400; k++) begin
            @(negedge clk);
            if (srcq[0].size() == 0 && srcq[1].size() == 0 && srcq[2].size() == 0 &&
                srcq[3].size() == 0 && pend == '0 && expq.size() == 0) break;
        end
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog expired", 64'(cyc), 64'd0);
        finish_run();
    end

    initial begin
        int f0, p0;
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk); #3;
        chk(wv == 1'b0, "R9 valid low in reset", 64'(wv), 64'd0);
        chk(req == 4'd0, "R9 no request in reset", 64'(req), 64'd0);
        rst = 1'b0;
        repeat (2) @(negedge clk);

        // Seven words on port 0 make one full word.
        #3;
        for (int k = 0; k < 7; k++) push(0, 32'hA0000000 + 32'(k), 2'(k));
        wait_drain();
        chk(full_cnt == 1 && part_cnt == 0, "R6 one full word", 64'(full_cnt), 64'd1);

        // Three words on port 2 leave a partial word for the timeout.
        #3;
        for (int k = 0; k < 3; k++) push(2, 32'hC2000000 + 32'(k), 2'd3);
        wait_drain();
        chk(part_cnt == 1, "R7 partial flush", 64'(part_cnt), 64'd1);

        // Port 1 context input is ignored.
        #3;
        push(1, 32'hB1000001, 2'd3);
        push(1, 32'hB1000002, 2'd2);
        wait_drain();
        chk(part_cnt == 2, "R5 port 1 flush", 64'(part_cnt), 64'd2);

        // Stray valid with no request, then one real word.
        @(negedge clk); #3;
        spur_req = 1'b1;
        repeat (4) @(negedge clk);
        #3;
        push(0, 32'hA5A5A5A5, 2'd1);
        wait_drain();
        chk(part_cnt == 3 && full_cnt == 1, "R2 stray valid ignored", 64'(part_cnt), 64'd3);

        // All ports loaded at once: priority order, one full plus one partial.
        #3;
        f0 = full_cnt; p0 = part_cnt;
        for (int k = 0; k < 3; k++) begin
            push(3, 32'hD3000000 + 32'(k), 2'd2);
            push(2, 32'hD2000000 + 32'(k), 2'd1);
            push(1, 32'hD1000000 + 32'(k), 2'd3);
            push(0, 32'hD0000000 + 32'(k), 2'd0);
        end
        wait_drain();
        chk(full_cnt - f0 == 1 && part_cnt - p0 == 1, "R1 R6 mixed load", 64'(full_cnt - f0), 64'd1);

        // Long mixed stream: 30 words give four full words and one partial.
        #3;
        f0 = full_cnt; p0 = part_cnt;
        for (int k = 0; k < 30; k++) push((k * 3) % 4, 32'hE0000000 + 32'(k), 2'(k));
        wait_drain();
        chk(full_cnt - f0 == 4, "R6 stream full words", 64'(full_cnt - f0), 64'd4);
        chk(part_cnt - p0 == 1, "R7 stream tail flush", 64'(part_cnt - p0), 64'd1);

        // Reset with a partial word held: it must never come out.
        #3;
        f0 = full_cnt; p0 = part_cnt;
        for (int k = 0; k < 3; k++) push(3, 32'hF3000000 + 32'(k), 2'd1);
        repeat (10) @(negedge clk);
        #3;
        rst = 1'b1;
        repeat (2) @(negedge clk);
        #3;
        expq.delete();
        expcyc.delete();
        chk(wv == 1'b0 && req == 4'd0, "R9 outputs quiet in reset", {59'd0, wv, req}, 64'd0);
        rst = 1'b0;
        repeat (120) @(negedge clk);
        chk(full_cnt == f0 && part_cnt == p0, "R9 held word discarded", 64'(part_cnt - p0), 64'd0);

        finish_run();
    end

endmodule